// File: doc/BRIEF.md
# PCM Bus Time-Slot Interface

This block places one 8-bit transmit word and takes one 8-bit receive word per frame on a serial PCM bus. It runs on the bus bit clock. Two separate frame-sync inputs mark the transmit frame and the receive frame, and the two frames may sit any number of bit clocks apart. The transmit word goes out MSB first, one bit per rising edge. The receive word is sampled MSB first on falling edges and is presented with a one-cycle valid strobe. A companding codec, or any other data source and sink, connects on the parallel side.

A mode input picks the frame-sync timing. In immediate timing the slot begins on the rising clock edge at which the sync is first seen high. In delayed timing the sync must already be high one bit clock before the slot, and the slot begins one bit clock later. Delayed timing also enables slot assignment. The sync then marks slot 0, and a per-direction counter finds the programmed slot. The block drives an active-low enable for an external backplane line driver, and this enable is released half a bit before the slot ends. After each slot it pulses a start strobe for encoding (transmit) or decoding (receive). While powered down, the transmit output stays undriven and no slot activity is produced.

Top module: `pcm_tsi`

## Requirements
- R1: After reset `dx_en_o`=0, `drv_en_no`=1, `rx_valid_o`=0, `enc_start_o`=0, `dec_start_o`=0 and `rx_byte_o`=0x00.
- R2: With `delayed_i`=0, the rising clock edge that first samples `fs_tx_i` high (previous sample low) drives bit 7 of `tx_byte_i` on `dx_o`. The next seven rising edges drive bits 6 down to 0. `dx_en_o` is 1 exactly for those 8 bit periods.
- R3: With `delayed_i`=1 and `tsa_en_i`=0, each slot (transmit and receive) begins one rising edge later than in R2.
- R4: With `delayed_i`=1 and `tsa_en_i`=1, the transmit slot begins 1+8·`tx_slot_i` edges after the edge that detects the sync rise. The receive slot begins 1+8·`rx_slot_i` edges after the edge that detects the receive sync rise.
- R5: With `delayed_i`=0, `tsa_en_i` and the slot numbers have no effect, and slot 0 is used.
- R6: `dr_i` is sampled on the falling edge inside each of the 8 receive bit periods, MSB first. On the rising edge after the 8th bit period, `rx_byte_o` takes the word and `rx_valid_o` is 1 for exactly one cycle.
- R7: Transmit and receive slot timing are independent, so a receive sync that trails the transmit sync by any number of bit clocks shifts only the receive slot.
- R8: `drv_en_no` goes low together with the first bit of the transmit slot. It returns high on the falling edge in the middle of the 8th bit period (7.5 bit times), and it is high at all other times.
- R9: `enc_start_o` pulses for one cycle on the rising edge that ends the transmit slot. `dec_start_o` pulses for one cycle together with `rx_valid_o`.
- R10: While `pd_i`=1, `dx_en_o`=0, `drv_en_no`=1, and no `rx_valid_o`, `enc_start_o` or `dec_start_o` pulse occurs, even when syncs arrive.
- R11: A sync held high for one bit clock and a sync held high for several bit clocks give identical slot timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fs_tx_i | input | 1 | Transmit frame sync |
| fs_rx_i | input | 1 | Receive frame sync |
| dr_i | input | 1 | Serial receive data |
| tx_byte_i | input | 8 | Word to transmit in the next transmit slot |
| delayed_i | input | 1 | 0 immediate timing, 1 delayed timing |
| tsa_en_i | input | 1 | Enable slot assignment (delayed timing only) |
| tx_slot_i | input | SLOT_W | Assigned transmit slot number |
| rx_slot_i | input | SLOT_W | Assigned receive slot number |
| pd_i | input | 1 | Power-down |
| dx_o | output | 1 | Serial transmit data |
| dx_en_o | output | 1 | Output-enable for the transmit pad (0 means high impedance) |
| drv_en_no | output | 1 | Backplane line-driver enable, active low |
| rx_byte_o | output | 8 | Last received word |
| rx_valid_o | output | 1 | One-cycle strobe: new word on `rx_byte_o` |
| enc_start_o | output | 1 | One-cycle strobe after the transmit slot |
| dec_start_o | output | 1 | One-cycle strobe after the receive slot |

## Verification
The assertions assume that a sync never rises again while its own slot is still in progress. They also assume that the mode, slot numbers and power-down are not changed in the middle of a frame. The one-cycle strobe and slot-length properties rely on this. The stimulus keeps syncs low for idle cycles between frames and sets the mode and slot inputs only in those gaps. Power-down is also toggled only in those gaps. Receive data is changed shortly after each rising edge, so it is stable well before the falling-edge sample.

// File: rtl/pcm_pkg.sv
`timescale 1ns/1ps
package pcm_pkg;
  localparam int unsigned WORD_BITS = 8;
  localparam int unsigned BIT_IDX_W = $clog2(WORD_BITS);
  typedef logic [WORD_BITS-1:0] pcm_word_t;
  typedef logic [BIT_IDX_W-1:0] bit_idx_t;
endpackage

// File: rtl/pcm_slot_timer.sv
`timescale 1ns/1ps
module pcm_slot_timer
  import pcm_pkg::*;
#(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_i,
  input  logic              pd_i,
  input  logic              delayed_i,
  input  logic              tsa_en_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              act_o,
  output bit_idx_t          bit_o
);
  localparam int unsigned POS_W = SLOT_W + BIT_IDX_W;

  logic              fs_q, run_q, rise;
  logic [POS_W-1:0]  cnt_q, pos;
  logic              pos_vld, at_end;
  logic [SLOT_W-1:0] eff_slot;

  assign rise     = fs_i & ~fs_q;
  assign eff_slot = (tsa_en_i & delayed_i) ? slot_i : '0;

  always_comb begin
    pos     = cnt_q;
    pos_vld = run_q;
    if (rise && !delayed_i) begin
      pos     = '0;
      pos_vld = 1'b1;
    end
    if (pd_i) pos_vld = 1'b0;
  end

  assign act_o  = pos_vld && (pos[POS_W-1:BIT_IDX_W] == eff_slot);
  assign bit_o  = pos[BIT_IDX_W-1:0];
  assign at_end = act_o && (bit_o == bit_idx_t'(WORD_BITS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_q  <= 1'b0;
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      fs_q <= fs_i;
      if (pd_i) begin
        run_q <= 1'b0;
      end else if (rise) begin
        run_q <= !(at_end);
        cnt_q <= delayed_i ? '0 : POS_W'(1);
      end else if (run_q) begin
        if (at_end) run_q <= 1'b0;
        else        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_tx_shift.sv
`timescale 1ns/1ps
module pcm_tx_shift
  import pcm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      act_i,
  input  bit_idx_t  bit_i,
  input  pcm_word_t word_i,
  output logic      dx_o,
  output logic      oe_o,
  output logic      last_o,
  output logic      half_o,
  output logic      done_o
);
  logic [WORD_BITS-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      dx_o   <= 1'b0;
      oe_o   <= 1'b0;
      last_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= oe_o & last_o;
      oe_o   <= act_i;
      last_o <= act_i && (bit_i == bit_idx_t'(WORD_BITS-1));
      if (act_i) begin
        if (bit_i == '0) begin
          dx_o <= word_i[WORD_BITS-1];
          sh_q <= word_i[WORD_BITS-2:0];
        end else begin
          dx_o <= sh_q[WORD_BITS-2];
          sh_q <= {sh_q[WORD_BITS-3:0], 1'b0};
        end
      end
    end
  end

  // mid-bit release of the line-driver enable in the last bit period
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_o <= 1'b0;
    else         half_o <= oe_o & last_o;
  end
endmodule

// File: rtl/pcm_rx_shift.sv
`timescale 1ns/1ps
module pcm_rx_shift
  import pcm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      act_i,
  input  bit_idx_t  bit_i,
  input  logic      dr_i,
  output pcm_word_t word_o,
  output logic      valid_o
);
  logic                 dr_s, act_q, last_q;
  logic [WORD_BITS-2:0] sh_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dr_s <= 1'b0;
    else         dr_s <= dr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      last_q  <= 1'b0;
      sh_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      act_q   <= act_i;
      last_q  <= act_i && (bit_i == bit_idx_t'(WORD_BITS-1));
      valid_o <= act_q & last_q;
      if (act_q) sh_q <= {sh_q[WORD_BITS-3:0], dr_s};
      if (act_q && last_q) word_o <= {sh_q, dr_s};
    end
  end
endmodule

// File: rtl/pcm_tsi.sv
`timescale 1ns/1ps
module pcm_tsi
  import pcm_pkg::*;
#(
  parameter int unsigned SLOT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_tx_i,
  input  logic              fs_rx_i,
  input  logic              dr_i,
  input  logic [7:0]        tx_byte_i,
  input  logic              delayed_i,
  input  logic              tsa_en_i,
  input  logic [SLOT_W-1:0] tx_slot_i,
  input  logic [SLOT_W-1:0] rx_slot_i,
  input  logic              pd_i,
  output logic              dx_o,
  output logic              dx_en_o,
  output logic              drv_en_no,
  output logic [7:0]        rx_byte_o,
  output logic              rx_valid_o,
  output logic              enc_start_o,
  output logic              dec_start_o
);
  logic     tx_act, rx_act;
  bit_idx_t tx_bit, rx_bit;
  logic     tx_oe, tx_last, tx_half, tx_done, rx_vld;
  pcm_word_t rx_word;

  pcm_slot_timer #(.SLOT_W(SLOT_W)) i_tx_tmr (
    .clk_i, .rst_ni, .fs_i(fs_tx_i), .pd_i, .delayed_i, .tsa_en_i,
    .slot_i(tx_slot_i), .act_o(tx_act), .bit_o(tx_bit)
  );

  pcm_slot_timer #(.SLOT_W(SLOT_W)) i_rx_tmr (
    .clk_i, .rst_ni, .fs_i(fs_rx_i), .pd_i, .delayed_i, .tsa_en_i,
    .slot_i(rx_slot_i), .act_o(rx_act), .bit_o(rx_bit)
  );

  pcm_tx_shift i_tx (
    .clk_i, .rst_ni, .act_i(tx_act), .bit_i(tx_bit), .word_i(tx_byte_i),
    .dx_o, .oe_o(tx_oe), .last_o(tx_last), .half_o(tx_half), .done_o(tx_done)
  );

  pcm_rx_shift i_rx (
    .clk_i, .rst_ni, .act_i(rx_act), .bit_i(rx_bit), .dr_i,
    .word_o(rx_word), .valid_o(rx_vld)
  );

  assign dx_en_o     = tx_oe & ~pd_i;
  assign drv_en_no   = ~(tx_oe & ~(tx_half & tx_last) & ~pd_i);
  assign rx_byte_o   = rx_word;
  assign rx_valid_o  = rx_vld & ~pd_i;
  assign dec_start_o = rx_vld & ~pd_i;
  assign enc_start_o = tx_done & ~pd_i;
endmodule

// File: rtl/pcm_tsi_chk.sv
`timescale 1ns/1ps
module pcm_tsi_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_i,
  input logic dx_en_o,
  input logic drv_en_no,
  input logic rx_valid_o,
  input logic enc_start_o
);
  logic [3:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_len <= '0;
    else if (dx_en_o) run_len <= (run_len == 4'hf) ? run_len : run_len + 1'b1;
    else              run_len <= '0;
  end

  a_r2_slot_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len <= 4'd8);
  a_r8_enn_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_no |-> dx_en_o);
  a_r8_enn_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dx_en_o) |-> !drv_en_no);
  a_r10_pd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_i |-> (!dx_en_o && drv_en_no && !rx_valid_o && !enc_start_o));
  a_r9_enc_after_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dx_en_o) && !pd_i) |-> enc_start_o);
  a_r9_enc_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_start_o |=> !enc_start_o);
  a_r6_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind pcm_tsi pcm_tsi_chk i_pcm_tsi_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pd_i(pd_i), .dx_en_o(dx_en_o),
  .drv_en_no(drv_en_no), .rx_valid_o(rx_valid_o), .enc_start_o(enc_start_o)
);

// File: tb/test_pcm_tsi.sv
`timescale 1ns/1ps
module test_pcm_tsi;
  localparam int SLOT_W = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fs_tx_i = 0, fs_rx_i = 0, dr_i = 1, delayed_i = 0, tsa_en_i = 0, pd_i = 0;
  logic [7:0] tx_byte_i = '0;
  logic [SLOT_W-1:0] tx_slot_i = '0, rx_slot_i = '0;
  logic dx_o, dx_en_o, drv_en_no, rx_valid_o, enc_start_o, dec_start_o;
  logic [7:0] rx_byte_o;

  int checks = 0, errors = 0;
  bit mon_on = 0, done = 0;
  bit exp_en = 0, exp_enn = 1, exp_enc = 0, exp_rv = 0;
  string cur_tag = "R2";
  logic [7:0] tx_q[$], rx_q[$];
  logic [7:0] tx_acc = '0;
  int tx_n = 0;

  always #5 clk_i = ~clk_i;

  pcm_tsi #(.SLOT_W(SLOT_W)) i_pcm_tsi (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // monitor / scoreboard: samples 8 ns after each rising edge
  initial forever begin
    @(posedge clk_i);
    #8;
    if (mon_on) begin
      chk(dx_en_o == exp_en, cur_tag, "dx_en_o", dx_en_o, exp_en);
      chk(drv_en_no == exp_enn, "R8", "drv_en_no", drv_en_no, exp_enn);
      chk(enc_start_o == exp_enc, "R9", "enc_start_o", enc_start_o, exp_enc);
      chk(rx_valid_o == exp_rv, "R6", "rx_valid_o", rx_valid_o, exp_rv);
      chk(dec_start_o == exp_rv, "R9", "dec_start_o", dec_start_o, exp_rv);
      if (dx_en_o) begin
        tx_acc = {tx_acc[6:0], dx_o};
        tx_n++;
        if (tx_n == 8) begin
          tx_n = 0;
          if (tx_q.size() == 0) chk(0, "R2", "unexpected tx word", tx_acc, 0);
          else begin
            logic [7:0] e;
            e = tx_q.pop_front();
            chk(tx_acc == e, "R2", "tx word", tx_acc, e);
          end
        end
      end
      if (rx_valid_o) begin
        if (rx_q.size() == 0) chk(0, "R6", "unexpected rx word", rx_byte_o, 0);
        else begin
          logic [7:0] e;
          e = rx_q.pop_front();
          chk(rx_byte_o == e, "R6", "rx word", rx_byte_o, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      fs_tx_i = 0; fs_rx_i = 0; dr_i = 1;
      exp_en = 0; exp_enn = 1; exp_enc = 0; exp_rv = 0;
      @(posedge clk_i); #2;
    end
  endtask

  // driver: one transmit and one receive frame; called 2 ns after a rising edge
  task automatic frame(input bit dly, input bit tsa, input int ts, input int rs,
                       input int rskew, input int fslen, input logic [7:0] txb,
                       input logic [7:0] rxb, input bit pdn, input string tag);
    int ets, ers, s, r, n, k;
    delayed_i = dly; tsa_en_i = tsa; pd_i = pdn;
    tx_slot_i = SLOT_W'(ts); rx_slot_i = SLOT_W'(rs); tx_byte_i = txb;
    cur_tag = tag;
    ets = (dly && tsa) ? ts : 0;
    ers = (dly && tsa) ? rs : 0;
    s = (dly ? 1 : 0) + 8 * ets;
    r = rskew + (dly ? 1 : 0) + 8 * ers;
    n = ((s > r) ? s : r) + 10;
    if (!pdn) begin
      tx_q.push_back(txb);
      rx_q.push_back(rxb);
    end
    for (int c = 0; c <= n; c++) begin
      k = c - 1;
      fs_tx_i = (c < fslen);
      fs_rx_i = (c >= rskew) && (c < rskew + fslen);
      dr_i = (k >= r && k <= r + 7) ? rxb[7 - (k - r)] : 1'b1;
      exp_en  = !pdn && (k >= s) && (k <= s + 7);
      exp_enn = !(!pdn && (k >= s) && (k <= s + 6));
      exp_enc = !pdn && (k == s + 8);
      exp_rv  = !pdn && (k == r + 8);
      @(posedge clk_i); #2;
    end
    pd_i = 0;
    idle(3);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk(dx_en_o == 0, "R1", "reset dx_en_o", dx_en_o, 0);
    chk(drv_en_no == 1, "R1", "reset drv_en_no", drv_en_no, 1);
    chk(rx_valid_o == 0 && enc_start_o == 0 && dec_start_o == 0, "R1", "reset strobes",
        {rx_valid_o, enc_start_o, dec_start_o}, 0);
    chk(rx_byte_o == 8'h00, "R1", "reset rx_byte_o", rx_byte_o, 0);
    rst_ni = 1;
    mon_on = 1;
    idle(3);
    frame(0, 0, 0, 0, 0, 1, 8'hA5, 8'h3C, 0, "R2");
    frame(0, 1, 3, 4, 3, 5, 8'h81, 8'h7E, 0, "R5");
    frame(1, 0, 0, 0, 11, 1, 8'h5A, 8'hC3, 0, "R3");
    frame(1, 1, 2, 5, 0, 4, 8'hF0, 8'h0F, 0, "R4");
    frame(1, 1, 0, 1, 6, 1, 8'h96, 8'h69, 0, "R7");
    frame(0, 0, 0, 0, 2, 3, 8'hFF, 8'h00, 1, "R10");
    frame(1, 0, 0, 0, 5, 6, 8'h3C, 8'hA5, 0, "R11");
    frame(0, 0, 0, 0, 0, 7, 8'h01, 8'h80, 0, "R11");
    idle(4);
    chk(tx_q.size() == 0, "R2", "tx words left", tx_q.size(), 0);
    chk(rx_q.size() == 0, "R6", "rx words left", rx_q.size(), 0);
    done = 1;
    mon_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule